// File: doc/BRIEF.md
# Programmable-Step Modulo-13 Counter

This block is a synchronous counter whose value stays within 0 to 12. On each clock edge where it is enabled, it adds a step to its value. The step is set at run time as a skip amount plus one. When the sum goes past 12, the counter wraps modulo 13 and keeps the excess, so one lap runs straight into the next instead of falling back to zero. With a skip of 4, for example, the counter visits 0, 5, 10, 2, 7, 12, 4, and so on. With a skip of zero it is an ordinary counter that goes from 12 back to 0.

Skip values from 0 to 11 are the legal range. Any larger value is clamped to 11, so an out-of-range input can never push the count outside its window. When enable is low the count holds its value. A change to skip takes effect on the next enabled edge. A synchronous active-high reset returns the count to zero.

Top module: `mod_step_counter`

## Requirements
- R1: The count output only ever holds a value from 0 to 12 inclusive.
- R2: While rst is high at a rising edge, the count becomes 0 after that edge, whatever the value of en. After reset is released, counting starts from 0.
- R3: At a rising edge with rst low and en high, the count becomes (count + skip + 1) mod 13, where skip is the value on the skip input at that edge.
- R4: With skip held at 0, successive enabled edges give 1, 2, …, 12, 0 and then repeat.
- R5: Starting from 0 with skip held at 4, successive enabled edges give 5, 10, 2, 7, 12, 4.
- R6: At a rising edge with rst low and en low, the count keeps its previous value.
- R7: A skip value of 12, 13, 14 or 15 advances the count exactly as a skip of 11 would (a step of 12).
- R8: Changes to skip while en is low do not alter the count. Only the skip value present at an enabled edge sets the step for that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high, overrides en |
| en | input | 1 | Count enable; advance when high, hold when low |
| skip | input | 4 | Skip amount; step is skip+1, values above 11 clamp to 11 |
| count | output | 4 | Registered count, 0 to 12 |

## Verification
The bench builds the block with its default parameters: a 4-bit count and a modulus of 13. These are small enough to sweep every skip value from 0 to 15 over two full laps each and compare every step against a modulo reference. That sweep reaches every reachable sum from 1 to 24, so both the wrap and non-wrap paths are covered, along with the largest sum of 24. The same settings also cover the clamp region, reset taking priority over enable, and skip changes made while the counter is held.

// File: rtl/step_ctr_pkg.sv
package step_ctr_pkg;
  // Default geometry of the counter.
  localparam int CNT_W_DEF   = 4;
  localparam int MODULUS_DEF = 13;
endpackage

// File: rtl/step_clamp.sv
// Limits the skip amount to the legal range and forms the step (skip+1).
module step_clamp #(
  parameter int W     = 4,
  parameter int LIMIT = 11
) (
  input  logic [W-1:0] skip_i,
  output logic [W:0]   step_o
);
  localparam logic [W:0] LIM_EXT = (W+1)'(LIMIT);

  logic [W:0] skip_ext;

  always_comb begin
    skip_ext = {1'b0, skip_i};
    if (skip_ext > LIM_EXT) step_o = LIM_EXT + 1'b1;
    else                    step_o = skip_ext + 1'b1;
  end

  // R7: an oversized skip produces the largest legal step
  always_comb begin
    if (skip_ext > LIM_EXT)
      a_clamp_top_r7: assert (step_o == LIM_EXT + 1'b1);
    a_step_bound_r1: assert (step_o >= 1 && step_o <= LIM_EXT + 1'b1);
  end
endmodule

// File: rtl/mod_wrap_add.sv
// Adds the step to the current value and folds the result back below MODULUS.
module mod_wrap_add #(
  parameter int W       = 4,
  parameter int MODULUS = 13
) (
  input  logic [W-1:0] cur_i,
  input  logic [W:0]   step_i,
  output logic [W-1:0] nxt_o
);
  localparam logic [W:0] MOD_EXT = (W+1)'(MODULUS);

  logic [W:0] sum;

  always_comb begin
    sum = {1'b0, cur_i} + step_i;
    if (sum >= MOD_EXT) nxt_o = W'(sum - MOD_EXT);
    else                nxt_o = W'(sum);
  end
endmodule

// File: rtl/count_reg.sv
// Holding register for the count with synchronous reset and enable.
module count_reg #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk) begin
    if (rst)     q_o <= '0;
    else if (en) q_o <= d_i;
  end

  // R2: reset clears the register regardless of enable
  p_reset_r2: assert property (@(posedge clk) rst |=> (q_o == '0));

  // R6: a disabled edge keeps the value
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(q_o));
endmodule

// File: rtl/mod_step_counter.sv
// Counter that advances by skip+1 per enabled edge and wraps modulo MODULUS.
module mod_step_counter
  import step_ctr_pkg::*;
#(
  parameter int CNT_W   = CNT_W_DEF,
  parameter int MODULUS = MODULUS_DEF
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] skip,
  output logic [CNT_W-1:0] count
);
  localparam int SKIP_MAX = MODULUS - 2;

  logic [CNT_W:0]   step;
  logic [CNT_W-1:0] next_val;

  step_clamp #(.W(CNT_W), .LIMIT(SKIP_MAX)) u_clamp (
    .skip_i (skip),
    .step_o (step)
  );

  mod_wrap_add #(.W(CNT_W), .MODULUS(MODULUS)) u_add (
    .cur_i  (count),
    .step_i (step),
    .nxt_o  (next_val)
  );

  count_reg #(.W(CNT_W)) u_reg (
    .clk (clk),
    .rst (rst),
    .en  (en),
    .d_i (next_val),
    .q_o (count)
  );

  // R1: the count never leaves its window
  p_range_r1: assert property (@(posedge clk) disable iff (rst)
    int'(count) < MODULUS);

  // R3: each enabled edge advances by the step, modulo MODULUS
  p_step_r3: assert property (@(posedge clk) disable iff (rst)
    en |=> int'(count) == (int'($past(count)) + int'($past(step))) % MODULUS);
endmodule

// File: tb/mod_step_counter_test.sv
module mod_step_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int MODV = 13;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en  = 1'b0;
  logic [3:0] skip = 4'd0;
  logic [3:0] count;

  int n_checks = 0;
  int n_fail   = 0;
  int model    = 0;

  mod_step_counter uut (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .skip  (skip),
    .count (count)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int eff_skip(input int s);
    return (s > 11) ? 11 : s;
  endfunction

  task automatic check(input int exp, input string req);
    n_checks++;
    if (int'(count) != exp) begin
      n_fail++;
      $display("FAIL %s: count=%0d expected=%0d at %0t", req, count, exp, $time);
    end
  endtask

  // One clock edge; inputs and samples change 1 time unit after the edge.
  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset;
    rst = 1'b1; en = 1'b1; skip = 4'd3;
    tick; tick;
    check(0, "R2 reset value");
    rst = 1'b0; en = 1'b0;
    model = 0;
  endtask

  task automatic t_plain;
    do_reset();
    skip = 4'd0; en = 1'b1;
    for (int i = 1; i <= 26; i++) begin
      tick;
      check(i % MODV, "R4 unit step");
    end
    en = 1'b0;
  endtask

  task automatic t_skip4;
    int seq[6] = '{5, 10, 2, 7, 12, 4};
    do_reset();
    skip = 4'd4; en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      tick;
      check(seq[i], "R5 skip-4 sequence");
    end
    en = 1'b0;
  endtask

  task automatic t_sweep;
    for (int s = 0; s < 16; s++) begin
      do_reset();
      skip = 4'(s); en = 1'b1;
      for (int i = 0; i < 26; i++) begin
        tick;
        model = (model + eff_skip(s) + 1) % MODV;
        check(model, (s > 11) ? "R7 clamped step" : "R3 modulo step");
        if (int'(count) > 12) begin
          n_checks++; n_fail++;
          $display("FAIL R1: count=%0d expected<=12", count);
        end
      end
      en = 1'b0;
    end
  endtask

  task automatic t_hold;
    do_reset();
    skip = 4'd6; en = 1'b1;
    tick; model = 7;
    check(model, "R3 first step");
    en = 1'b0;
    for (int i = 0; i < 5; i++) begin
      skip = 4'(i * 3);
      tick;
      check(model, "R6/R8 hold while disabled");
    end
    skip = 4'd2; en = 1'b1;
    tick; model = (model + 3) % MODV;
    check(model, "R8 new skip at enabled edge");
    en = 1'b0;
  endtask

  task automatic t_reset_priority;
    do_reset();
    skip = 4'd9; en = 1'b1;
    tick; tick;
    check(7, "R3 pre-reset value");
    rst = 1'b1;
    tick;
    check(0, "R2 reset over enable");
    rst = 1'b0;
    tick;
    check(10, "R2 count restarts from 0");
    en = 1'b0;
  endtask

  initial begin
    tick;
    check(0, "R2 initial reset");
    t_plain();
    t_skip4();
    t_sweep();
    t_hold();
    t_reset_priority();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule